// File: doc/BRIEF.md
# Bus and Pin Wake-up Source Detector

This block watches two wake sources for a bus transceiver's mode controller. The first is a digital wake pin. The second is the bus receiver's output, where 1 means recessive and 0 means dominant. When either source presents a valid wake request, the block issues a one-cycle wake pulse. It also keeps a flag that tells whether the most recent wake came over the bus, so that the receive output can report the wake source to the host until communication resumes.

The pin source uses a debounce filter. A change in either direction counts only while the part sleeps. The bus source uses a three-step sequence: a falling edge, then a dominant level held longer than a timeout, then a rising edge. This sequence is tracked in both low-power modes. Both filter times are parameters given in clock cycles. Both inputs are synchronized to the clock before any edge is examined.

Top module: `wake_src_detect`

## Requirements
- R1: While reset is low and in the cycle after it is released, `wake_o` and `remote_o` are 0.
- R2: Each of `wake_pin_i` and `bus_rx_i` passes through `SYNC_STAGES` (at least 2) flops before use. With 2 stages, a pin change driven just before clock edge 0 raises `wake_o` just after clock edge `PIN_DEB_CYC`+1.
- R3: In sleep (`mode_i` = 2'b00), a new pin level seen on `PIN_DEB_CYC` consecutive synchronized samples is accepted. This produces a wake pulse for a low-to-high change and for a high-to-low change alike.
- R4: A pin change that lasts fewer than `PIN_DEB_CYC` samples gives no pulse and does not move the accepted level.
- R5: In standby (2'b01), normal (2'b10) and low-slope (2'b11), pin activity gives no pulse. The accepted level follows the pin, so returning to sleep gives no stale pulse.
- R6: In an active mode, a bus wake needs all three steps: a 1-to-0 edge, then more than `DOM_TMO_CYC` dominant samples counted from the edge sample, then a 0-to-1 edge. The pulse follows the rising edge by one cycle.
- R7: A dominant stretch of `DOM_TMO_CYC` samples or fewer is discarded. The detector then waits for a fresh falling edge.
- R8: Bus wake detection is active only in sleep and standby. Any other mode abandons a sequence that is in progress.
- R9: However long the dominant level lasts, the dominant counter saturates and exactly one pulse is issued, on the rising edge.
- R10: `remote_o` rises the cycle after a bus wake pulse. It holds through sleep and standby. It clears the cycle after `mode_i` is normal or low-slope.
- R11: A pin wake pulse clears `remote_o`. If both sources pulse in the same cycle, the bus source wins.
- R12: Each source's wake pulse is exactly one clock wide.
- R13: A dominant level already present when detection becomes active starts no sequence, because no falling edge was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 sleep, 01 standby, 10 normal, 11 low-slope |
| wake_pin_i | input | 1 | Asynchronous wake pin level |
| bus_rx_i | input | 1 | Asynchronous bus receiver level, 1 recessive, 0 dominant |
| wake_o | output | 1 | One-cycle wake pulse from either source |
| remote_o | output | 1 | Last wake came from the bus |

## Verification
The bench probes the exact boundary of both filters. A dominant stretch of exactly the timeout must be dropped, and one sample more must wake. A pin glitch one sample short of the debounce must leave the accepted level unchanged. A design with an off-by-one in either counter would wake one cycle early or miss these cases. The bench also holds the bus dominant far past the timeout, to catch a design that pulses at saturation instead of on the rising edge. It leaves an active mode partway through a sequence, and it enters sleep with the bus already dominant. A detector that keeps its count across those transitions, or that treats a level as an edge, would report a wake that never happened. Finally, it checks that the source flag survives standby, is cleared by a normal-mode entry or by a later pin wake, and is not set by pin activity outside sleep.

// File: rtl/wkd_pkg.sv
package wkd_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP    = 2'b00,
      MODE_STANDBY  = 2'b01,
      MODE_NORMAL   = 2'b10,
      MODE_LOWSLOPE = 2'b11
   } opmode_e;

   typedef enum logic [1:0] {
      RW_IDLE = 2'b00,
      RW_DOM  = 2'b01,
      RW_LONG = 2'b10
   } rw_state_e;

   function automatic logic is_comm_mode(input opmode_e m);
      return (m == MODE_NORMAL) || (m == MODE_LOWSLOPE);
   endfunction

   function automatic logic bus_wake_armed(input opmode_e m);
      return (m == MODE_SLEEP) || (m == MODE_STANDBY);
   endfunction

endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/wkd_local.sv
module wkd_local #(
   parameter int DEB_CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic lvl_i,
   output logic pulse_o
);

   localparam int CNT_W = $clog2(DEB_CYC + 1);
   localparam logic [CNT_W-1:0] DEB_LAST = CNT_W'(DEB_CYC - 1);

   logic             acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= 1'b0;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (!sleep_i) begin
            acc_q <= lvl_i;
            cnt_q <= '0;
         end else if (lvl_i == acc_q) begin
            cnt_q <= '0;
         end else if (cnt_q == DEB_LAST) begin
            acc_q   <= lvl_i;
            cnt_q   <= '0;
            pulse_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pulse_o = pulse_q;

   assert_pin_only_in_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(sleep_i));

   assert_pin_level_flipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (acc_q != $past(acc_q)));

   assert_pin_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/wkd_remote.sv
module wkd_remote
   import wkd_pkg::*;
#(
   parameter int TMO_CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic rx_i,
   output logic pulse_o
);

   localparam int CNT_W = $clog2(TMO_CYC + 1);
   localparam logic [CNT_W-1:0] TMO_L = CNT_W'(TMO_CYC);
   localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

   rw_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rx_q;
   logic             pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RW_IDLE;
         cnt_q   <= '0;
         rx_q    <= 1'b1;
         pulse_q <= 1'b0;
      end else begin
         rx_q    <= rx_i;
         pulse_q <= 1'b0;
         if (!active_i) begin
            state_q <= RW_IDLE;
            cnt_q   <= '0;
         end else begin
            case (state_q)
               RW_IDLE: begin
                  if (rx_q && !rx_i) begin
                     state_q <= RW_DOM;
                     cnt_q   <= ONE_L;
                  end
               end
               RW_DOM: begin
                  if (rx_i) begin
                     state_q <= RW_IDLE;
                     cnt_q   <= '0;
                  end else if (cnt_q == TMO_L) begin
                     state_q <= RW_LONG;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RW_LONG: begin
                  if (rx_i) begin
                     state_q <= RW_IDLE;
                     cnt_q   <= '0;
                     pulse_q <= 1'b1;
                  end
               end
               default: begin
                  state_q <= RW_IDLE;
                  cnt_q   <= '0;
               end
            endcase
         end
      end
   end

   assign pulse_o = pulse_q;

   assert_dom_cnt_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TMO_L);

   assert_bus_pulse_after_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> ($past(state_q) == RW_LONG));

   assert_bus_only_when_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(active_i));

   assert_bus_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/wake_src_detect.sv
module wake_src_detect
   import wkd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PIN_DEB_CYC = 500,
   parameter int DOM_TMO_CYC = 2500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       wake_pin_i,
   input  logic       bus_rx_i,
   output logic       wake_o,
   output logic       remote_o
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PIN_DEB_CYC < 1) begin : g_chk_deb
      $error("PIN_DEB_CYC must be at least 1");
   end
   if (DOM_TMO_CYC < 1) begin : g_chk_tmo
      $error("DOM_TMO_CYC must be at least 1");
   end

   opmode_e mode;
   logic    pin_s, bus_s;
   logic    pin_pulse, bus_pulse;
   logic    remote_q;

   assign mode = opmode_e'(mode_i);

   wkd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
      .clk(clk), .rst_n(rst_n), .d_i(wake_pin_i), .q_o(pin_s));

   wkd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_rx_i), .q_o(bus_s));

   wkd_local #(.DEB_CYC(PIN_DEB_CYC)) i_local (
      .clk(clk), .rst_n(rst_n), .sleep_i(mode == MODE_SLEEP),
      .lvl_i(pin_s), .pulse_o(pin_pulse));

   wkd_remote #(.TMO_CYC(DOM_TMO_CYC)) i_remote (
      .clk(clk), .rst_n(rst_n), .active_i(bus_wake_armed(mode)),
      .rx_i(bus_s), .pulse_o(bus_pulse));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  remote_q <= 1'b0;
      else if (is_comm_mode(mode)) remote_q <= 1'b0;
      else if (bus_pulse)          remote_q <= 1'b1;
      else if (pin_pulse)          remote_q <= 1'b0;
   end

   assign wake_o   = pin_pulse | bus_pulse;
   assign remote_o = remote_q;

   assert_flag_set_by_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_q) |-> $past(bus_pulse));

   assert_flag_clear_in_comm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_comm_mode(mode) |=> !remote_q);

   assert_pin_wake_clears_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pulse && !bus_pulse) |=> !remote_q);

endmodule

// File: tb/test_wake_src_detect.sv
module test_wake_src_detect;

   localparam int DEB = 6;
   localparam int TMO = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b01;
   logic       wpin = 1'b0;
   logic       brx = 1'b1;
   logic       wake_o, remote_o;

   int vectors = 0;
   int miscompares = 0;
   int pulses = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   wake_src_detect #(.SYNC_STAGES(2), .PIN_DEB_CYC(DEB), .DOM_TMO_CYC(TMO)) i_wake_src_detect (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .wake_pin_i(wpin),
      .bus_rx_i(brx), .wake_o(wake_o), .remote_o(remote_o));

   // behavioural reference: delayed samples, run lengths, pending flags
   int hw[$], hb[$];
   int m_acc, m_run, m_prev, m_rd, m_pl, m_pr, m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         hw = '{0, 0}; hb = '{1, 1};
         m_acc = 0; m_run = 0; m_prev = 1; m_rd = -1;
         m_pl = 0; m_pr = 0; m_flag = 0;
      end else begin
         int sw, sb, opl, opr;
         sw = hw[1]; sb = hb[1];
         opl = m_pl; opr = m_pr;
         if (mode >= 2) m_flag = 0;
         else if (opr != 0) m_flag = 1;
         else if (opl != 0) m_flag = 0;
         m_pl = 0;
         if (mode != 0) begin m_acc = sw; m_run = 0; end
         else if (sw == m_acc) m_run = 0;
         else begin
            m_run++;
            if (m_run == DEB) begin m_acc = sw; m_run = 0; m_pl = 1; end
         end
         m_pr = 0;
         if (mode >= 2) m_rd = -1;
         else if (m_rd < 0) begin
            if (m_prev == 1 && sb == 0) m_rd = 1;
         end else if (sb == 0) begin
            if (m_rd <= TMO) m_rd++;
         end else begin
            if (m_rd > TMO) m_pr = 1;
            m_rd = -1;
         end
         m_prev = sb;
         hw.pop_back(); hw.push_front(int'(wpin));
         hb.pop_back(); hb.push_front(int'(brx));
      end
   end

   always @(posedge clk) if (rst_n && wake_o) pulses++;

   always @(negedge clk) begin
      int ew, ef;
      ew = (m_pl != 0 || m_pr != 0) ? 1 : 0;
      ef = m_flag;
      if (!rst_n) begin ew = 0; ef = 0; end
      vectors++;
      if (int'(wake_o) != ew || int'(remote_o) != ef) begin
         miscompares++;
         $display("FAIL %s cycle compare: wake=%0d remote=%0d expected wake=%0d remote=%0d",
                  cur_req, wake_o, remote_o, ew, ef);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp, input string what);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic dom_pulse(input int n);
      brx = 1'b0; wait_cyc(n); brx = 1'b1; wait_cyc(20);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      check("R1", int'(wake_o) + int'(remote_o), 0, "outputs in reset");
      rst_n = 1'b1;
      wait_cyc(1);
      check("R1", int'(wake_o) + int'(remote_o), 0, "outputs after reset");

      cur_req = "R5"; pulses = 0;
      wpin = 1; wait_cyc(20); wpin = 0; wait_cyc(20); wpin = 1; wait_cyc(20);
      check("R5", pulses, 0, "pin pulses in standby");
      mode = 2'b00; wait_cyc(20);
      check("R5", pulses, 0, "stale pulse on sleep entry");
      wpin = 0; wait_cyc(20);

      cur_req = "R4"; pulses = 0;
      wpin = 1; wait_cyc(DEB - 1); wpin = 0; wait_cyc(20);
      check("R4", pulses, 0, "glitch one short of debounce");

      cur_req = "R2"; pulses = 0;
      begin
         int lat = 0;
         wpin = 1;
         while (!wake_o && lat < 50) begin wait_cyc(1); lat++; end
         check("R2", lat, DEB + 2, "pin-to-pulse latency");
      end
      wait_cyc(20);
      cur_req = "R3"; pulses = 0;
      wpin = 0; wait_cyc(30);
      check("R3", pulses, 1, "falling pin edge wakes");
      check("R3", int'(remote_o), 0, "pin wake leaves flag low");

      cur_req = "R7"; pulses = 0;
      dom_pulse(8); dom_pulse(TMO);
      check("R7", pulses, 0, "dominant at or below timeout");

      cur_req = "R6"; pulses = 0;
      dom_pulse(TMO + 1);
      check("R6", pulses, 1, "dominant one past timeout");
      check("R10", int'(remote_o), 1, "flag after bus wake");

      cur_req = "R11"; pulses = 0;
      wpin = 1; wait_cyc(30);
      check("R11", pulses, 1, "pin wake after bus wake");
      check("R11", int'(remote_o), 0, "pin wake clears flag");

      cur_req = "R9"; pulses = 0;
      brx = 0; wait_cyc(150);
      check("R9", pulses, 0, "no pulse while dominant held");
      brx = 1; wait_cyc(20);
      check("R9", pulses, 1, "single pulse on release");

      cur_req = "R8"; pulses = 0;
      mode = 2'b01; wait_cyc(5);
      dom_pulse(20);
      check("R8", pulses, 1, "bus wake in standby");
      wait_cyc(30);
      check("R10", int'(remote_o), 1, "flag holds in standby");
      cur_req = "R10";
      mode = 2'b10; wait_cyc(3);
      check("R10", int'(remote_o), 0, "normal mode clears flag");
      cur_req = "R8"; pulses = 0;
      dom_pulse(40);
      mode = 2'b11; dom_pulse(40);
      check("R8", pulses, 0, "no bus wake in communication modes");

      pulses = 0;
      mode = 2'b01; wait_cyc(5);
      brx = 0; wait_cyc(5); mode = 2'b10; wait_cyc(3); mode = 2'b01;
      wait_cyc(30); brx = 1; wait_cyc(20);
      check("R8", pulses, 0, "sequence abandoned on mode change");

      cur_req = "R13"; pulses = 0;
      mode = 2'b10; brx = 0; wait_cyc(10);
      mode = 2'b00; wait_cyc(40); brx = 1; wait_cyc(20);
      check("R13", pulses, 0, "dominant at activation ignored");
      dom_pulse(TMO + 3);
      check("R13", pulses, 1, "fresh edge after that wakes");
      check("R12", int'(wake_o), 0, "pulse has ended");

      wait_cyc(5);
      finish_run();
   end

endmodule